// File: doc/BRIEF.md
# Dual-Rate Word Serializer

This block is the digital transmit datapath of a serial link. It takes 10-bit code groups that are already line-coded and arrive on a parallel bus with a source-synchronous byte clock. It sends them one bit at a time on a fast serial clock that runs twenty times faster than the byte clock. A rate input picks the capture cadence. In full rate, a word rides on every byte-clock edge, rising and falling. In half rate, only the falling edge carries a word, and the data holds steady across the rising edge. The serial output keeps one word per half byte period in full rate and one word per byte period in half rate.

All logic runs on the serial clock. The byte clock passes through a two-stage synchronizer. Each qualifying edge starts a short delay counter, which puts the capture point in the middle of the data window. A captured word is tagged with the rate that was in force and pushed into a two-entry holding queue. A shifter takes words from this queue and sends bit 0 first. In half rate it holds each bit for two serial clocks. A loopback path returns each captured word to a parallel receive port and skips the serial path.

The capture side has no ready signal. The sender is source-synchronous and cannot be stalled. The receive strobe likewise has no back-pressure, so whatever consumes it must take one word on each pulse. Matched rates keep the queue from filling. To change rate, stop the byte clock and let the queue drain before switching.

Top module: `ddr_word_serializer`

## Requirements
- R1: While reset is high, and after it until the first captured word reaches the shifter, `sout` is 0 and `rx_valid` is 0.
- R2: With `rate_full`=1, every rising and every falling byte-clock edge captures the word on `tx_data`, and the words come out in arrival order.
- R3: Each word is sent with `tx_data[0]` first and `tx_data[9]` last. A word is sent in full before the next starts, and at matched rate there are no idle cycles between words.
- R4: With `rate_full`=0, only falling edges capture a word. Each bit is driven for two serial clocks, so one word lasts twenty serial clocks.
- R5: The rate used to send a word is the rate sampled when that word was captured. Changing `rate_full` while a word is being sent does not change that word's bit timing.
- R6: All 1024 code values pass through unchanged. The block applies no encoding.
- R7: With `lb_en`=1, `rx_valid` pulses for one cycle per captured word and `rx_data` carries that word, in order. With `lb_en`=0, `rx_valid` stays 0.
- R8: When no word is pending, `sout` is 0.
- R9: At matched rates, the holding queue never receives a word while it holds two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, 20x the byte clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_clk | input | 1 | Source-synchronous byte clock |
| tx_data | input | 10 | Parallel code group, bit 0 sent first |
| rate_full | input | 1 | 1: capture on both edges; 0: falling edge only, bits doubled |
| lb_en | input | 1 | Enables the parallel loopback output |
| sout | output | 1 | Serial data output |
| rx_valid | output | 1 | One-cycle strobe per looped-back word |
| rx_data | output | 10 | Looped-back word |

## Verification
The bench sends all 1024 code values at full rate, then 256 words at half rate, then a short full-rate burst after a rate switch. It rebuilds every word from the serial stream at a fixed bit spacing.

Each error shows up in a specific way:
- A shifter that reloads one cycle late, or a queue that drops a word, shifts every later word and breaks the alignment.
- Capturing on rising edges in half rate puts extra words on the line.
- Re-reading the rate in the middle of a word cuts the last half-rate word short.
- Reversed bit order or a loopback that is not gated shows up as mismatched words or stray strobes.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  parameter int unsigned WORD_W = 10;

  typedef struct packed {
    logic                  half;
    logic [WORD_W-1:0]     data;
  } tagged_word_t;
endpackage

// File: rtl/sertx_edge_capture.sv
module sertx_edge_capture
  import sertx_pkg::*;
#(
  parameter int unsigned CAP_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_clk,
  input  logic              rate_full,
  input  logic [WORD_W-1:0] tx_data,
  output logic              fire,
  output tagged_word_t      word
);
  localparam int unsigned CW = $clog2(CAP_DLY + 1);

  logic          bc_s1, bc_s2, bc_s3;
  logic          rt_s1, rt_s2;
  logic [CW-1:0] cnt;
  logic          tag_half;
  logic          rise, fall, qual;

  assign rise = bc_s2 & ~bc_s3;
  assign fall = ~bc_s2 & bc_s3;
  assign qual = fall | (rise & rt_s2);

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_s1    <= 1'b0;
      bc_s2    <= 1'b0;
      bc_s3    <= 1'b0;
      rt_s1    <= 1'b0;
      rt_s2    <= 1'b0;
      cnt      <= '0;
      tag_half <= 1'b0;
    end else begin
      bc_s1 <= byte_clk;
      bc_s2 <= bc_s1;
      bc_s3 <= bc_s2;
      rt_s1 <= rate_full;
      rt_s2 <= rt_s1;
      if (qual) begin
        cnt      <= CW'(CAP_DLY);
        tag_half <= ~rt_s2;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign fire      = (cnt == CW'(1));
  assign word.half = tag_half;
  assign word.data = tx_data;

  // R2: one capture per qualifying edge, never two in a row
  a_r2_single_fire: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  // R4: a rising edge seen in half rate never starts a capture
  a_r4_no_rise_capture: assert property (@(posedge clk) disable iff (rst)
    (rise && !rt_s2 && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/sertx_hold_fifo.sv
module sertx_hold_fifo
  import sertx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  tagged_word_t din,
  input  logic         pop,
  output tagged_word_t dout,
  output logic         nonempty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  tagged_word_t  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign full     = (cnt == CW'(DEPTH));
  assign nonempty = (cnt != '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;
  assign dout     = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (do_pop)
        rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: no word arrives while the queue is full
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R9: occupancy never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         word_valid,
  input  tagged_word_t word,
  output logic         pop,
  output logic         sout
);
  localparam int unsigned BW = $clog2(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [BW-1:0]     bits_left;
  logic              hold;
  logic              cur_half;
  logic              busy;
  logic              last, can_load;

  assign last     = busy && (bits_left == '0) && !hold;
  assign can_load = !busy || last;
  assign pop      = can_load && word_valid;
  assign sout     = busy & shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bits_left <= '0;
      hold      <= 1'b0;
      cur_half  <= 1'b0;
      busy      <= 1'b0;
    end else if (can_load) begin
      if (word_valid) begin
        shreg     <= word.data;
        bits_left <= BW'(WORD_W - 1);
        hold      <= word.half;
        cur_half  <= word.half;
        busy      <= 1'b1;
      end else begin
        busy  <= 1'b0;
        shreg <= '0;
      end
    end else if (hold) begin
      hold <= 1'b0;
    end else begin
      shreg     <= {1'b0, shreg[WORD_W-1:1]};
      bits_left <= bits_left - 1'b1;
      hold      <= cur_half;
    end
  end

  // R3: no word is taken while the current one is still being sent
  a_r3_no_midword_load: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |-> !pop);
  // R5: the pacing of a word stays fixed until its last bit
  a_r5_rate_held: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(cur_half));
endmodule

// File: rtl/ddr_word_serializer.sv
module ddr_word_serializer
  import sertx_pkg::*;
#(
  parameter int unsigned CAP_DLY    = 3,
  parameter int unsigned HOLD_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_clk,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              rate_full,
  input  logic              lb_en,
  output logic              sout,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  logic         fire, q_valid, pop;
  tagged_word_t cap_word, q_word;

  sertx_edge_capture #(.CAP_DLY(CAP_DLY)) u_cap (
    .clk(clk), .rst(rst), .byte_clk(byte_clk), .rate_full(rate_full),
    .tx_data(tx_data), .fire(fire), .word(cap_word)
  );

  sertx_hold_fifo #(.DEPTH(HOLD_DEPTH)) u_hold (
    .clk(clk), .rst(rst), .push(fire), .din(cap_word),
    .pop(pop), .dout(q_word), .nonempty(q_valid)
  );

  sertx_shifter u_shift (
    .clk(clk), .rst(rst), .word_valid(q_valid), .word(q_word),
    .pop(pop), .sout(sout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= fire & lb_en;
      if (fire && lb_en) rx_data <= cap_word.data;
    end
  end

  // R1: the cycle after reset the outputs are quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!sout && !rx_valid));
  // R7: a loopback strobe only follows an enabled cycle
  a_r7_loopback_gated: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(lb_en));
endmodule

// File: tb/ddr_word_serializer_bench.sv
module ddr_word_serializer_bench;
  localparam int CLK_NS  = 2;
  localparam int NBITS   = 40000;
  localparam int N_FULL  = 1024;
  localparam int N_HALF  = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_clk = 1'b0;
  logic [9:0] tx_data = '0;
  logic       rate_full = 1'b1;
  logic       lb_en = 1'b1;
  logic       sout, rx_valid;
  logic [9:0] rx_data;

  int checks = 0;
  int errors = 0;
  logic bits [NBITS];
  int   nb = 0;
  bit   rec = 1'b0;
  logic [9:0] rx_log [2048];
  int   nrx = 0;

  ddr_word_serializer u_ddr_word_serializer (
    .clk(clk), .rst(rst), .byte_clk(byte_clk), .tx_data(tx_data),
    .rate_full(rate_full), .lb_en(lb_en), .sout(sout),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (rec && nb < NBITS) begin
      bits[nb] = sout;
      nb++;
    end
    if (rx_valid && nrx < 2048) begin
      rx_log[nrx] = rx_data;
      nrx++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find_one(input int from);
    for (int i = from; i < nb; i++) if (bits[i] === 1'b1) return i;
    return -1;
  endfunction

  function automatic logic [9:0] full_word(input int k);
    return 10'((k + 1) & 1023);
  endfunction

  function automatic logic [9:0] half_word(input int k);
    return 10'((k * 397 + 1) & 1023);
  endfunction

  function automatic logic [9:0] tail_word(input int k);
    case (k)
      0: return 10'h3A5;
      1: return 10'h0F0;
      2: return 10'h155;
      default: return 10'h2AA;
    endcase
  endfunction

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p1, p2, p3, s, nrx_before, bad, z;
    logic [9:0] got;
    // reset state, R1
    repeat (5) @(negedge clk);
    check(sout === 1'b0, "R1 sout in reset", int'(sout), 0);
    check(rx_valid === 1'b0, "R1 rx_valid in reset", int'(rx_valid), 0);
    rst = 1'b0;
    rec = 1'b1;
    repeat (4) @(negedge clk);
    check(sout === 1'b0, "R1 sout before first word", int'(sout), 0);

    // phase 1: full rate, every code value
    p1 = nb;
    for (int k = 0; k < N_FULL; k++) begin
      byte_clk = ~byte_clk;
      tx_data  = full_word(k);
      repeat (10) @(negedge clk);
    end
    repeat (40) @(negedge clk);

    s = find_one(p1);
    check(s >= p1 && s - p1 < 20, "R1 first word latency", s - p1, 8);
    bad = 0;
    for (int k = 0; k < N_FULL; k++) begin
      for (int b = 0; b < 10; b++) got[b] = bits[s + k*10 + b];
      if (got !== full_word(k)) bad++;
      check(got === full_word(k), "R2/R3 full-rate word", int'(got), int'(full_word(k)));
    end
    check(bad == 0, "R6 all codes unchanged", bad, 0);
    z = 0;
    for (int i = s + N_FULL*10; i < nb; i++) if (bits[i] !== 1'b0) z++;
    check(z == 0, "R8 idle line low after stream", z, 0);
    check(nrx == N_FULL, "R7 loopback word count", nrx, N_FULL);
    bad = 0;
    for (int k = 0; k < N_FULL && k < nrx; k++) if (rx_log[k] !== full_word(k)) bad++;
    check(bad == 0, "R7 loopback word order", bad, 0);

    // phase 2: half rate, loopback off
    rate_full = 1'b0;
    lb_en     = 1'b0;
    repeat (10) @(negedge clk);
    nrx_before = nrx;
    p2 = nb;
    for (int k = 0; k < N_HALF; k++) begin
      tx_data  = half_word(k);
      byte_clk = 1'b1;
      repeat (10) @(negedge clk);
      byte_clk = 1'b0;
      repeat (10) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    rate_full = 1'b1;   // switch while the last word is still going out
    repeat (60) @(negedge clk);

    s = find_one(p2);
    for (int k = 0; k < N_HALF; k++) begin
      bad = 0;
      for (int b = 0; b < 10; b++) begin
        got[b] = bits[s + k*20 + 2*b];
        if (bits[s + k*20 + 2*b + 1] !== got[b]) bad++;
      end
      if (k == N_HALF - 1)
        check(got === half_word(k) && bad == 0, "R5 last word keeps half pacing",
              int'(got), int'(half_word(k)));
      else
        check(got === half_word(k) && bad == 0, "R4 half-rate word",
              int'(got), int'(half_word(k)));
    end
    z = 0;
    for (int i = s + N_HALF*20; i < nb; i++) if (bits[i] !== 1'b0) z++;
    check(z == 0, "R4 no words from rising edges", z, 0);
    check(nrx == nrx_before, "R7 no strobe with loopback off", nrx - nrx_before, 0);

    // phase 3: full rate again after the switch
    p3 = nb;
    for (int k = 0; k < 4; k++) begin
      byte_clk = ~byte_clk;
      tx_data  = tail_word(k);
      repeat (10) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    s = find_one(p3);
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 10; b++) got[b] = bits[s + k*10 + b];
      check(got === tail_word(k), "R5 new rate after boundary", int'(got), int'(tail_word(k)));
    end
    z = 0;
    for (int i = s + 40; i < nb; i++) if (bits[i] !== 1'b0) z++;
    check(z == 0, "R8 line low after burst", z, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule